// File: doc/BRIEF.md
# Configurable UART Line Framer

This block is an asynchronous serial transmitter and receiver pair with framing chosen at run time. Software sets the character length (5 to 8 bits), the stop-bit length and the parity mode through a line control register. A 16-bit divisor sets the baud tick rate, and each serial bit lasts 16 ticks. A one-character holding register feeds the transmit shifter. A one-character buffer holds received data, and a status register reports its condition.

The divisor shares the two lowest register addresses with the data and unused registers. An access bit in the line control register selects which of them those addresses reach. The receiver samples each bit at its middle and rejects start pulses shorter than half a bit. It flags parity, framing, break and overrun conditions. A loopback control routes the transmitter line straight into the receiver and holds the external output idle. Software then checks the whole path with no wiring outside the block.

Top module: `uart_framer`

## Requirements
- R1: After reset, the line status register (address 2) reads 0x60, the line control register (address 3) reads 0x00 and txd_o is 1.
- R2: While line control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte. A write to address 0 then does not load the transmit holding register.
- R3: One serial bit lasts 16 × divisor clock cycles. A transmitted frame is a 0 start bit, then the data bits LSB first, then the optional parity bit, then stop bits at 1.
- R4: Line control bits [1:0] = 0,1,2,3 select 5,6,7,8 data bits. Received data bits above the configured length read as 0.
- R5: Line control bit 3 enables a parity bit and bit 4 selects even parity (the total count of ones in data plus parity is even) over odd. A received parity mismatch sets status bit 2.
- R6: Line control bit 2 = 0 gives one stop bit. Bit 2 = 1 gives 1.5 stop bits for 5-bit characters and 2 stop bits for 6 to 8-bit characters.
- R7: Status bit 0 is set when a character is received and cleared by a read of address 0 with line control bit 7 = 0.
- R8: If a character completes while status bit 0 is still set, status bit 1 (overrun) is set and the receive buffer holds the newer character.
- R9: A stop bit sampled at 0 sets status bit 3. A frame that is 0 for every bit up to and including the stop bit also sets status bit 4. A read of the status register clears bits 1 to 4.
- R10: Status bit 5 is 1 when the transmit holding register is empty. Status bit 6 is 1 only when both the holding register and the shifter are empty.
- R11: With bit 0 of the loop control register (address 4) at 1, the transmitter line drives the receiver and txd_o stays at 1.
- R12: A low pulse on the receive line that has ended by mid-bit (8 ticks after detection) is ignored and sets no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; triggers read side effects |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |

## Verification
The bench measures the length of each frame format on the line, including the 1.5-stop-bit case. A design that used the wrong stop count for a word length would start the next queued character a half or whole bit off. It sends short characters with set upper bits through loopback; a receiver that did not mask would return those upper bits. It drives break frames and frames with a bad stop bit or bad parity, and it checks that a status read clears the error bits while data ready survives. It also sends an overrun pair and a start glitch. A design that kept the older character, or that took a glitch as a start bit, would then show the wrong buffer value or a false data ready.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_DIVH = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_LCTL = 3'd3;
  localparam logic [2:0] A_LOOP = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } line_st_e;

  typedef struct packed {
    logic       dlab;
    logic [1:0] spare;
    logic       even;
    logic       par_en;
    logic       xstop;
    logic [1:0] wlen;
  } lctl_t;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_framer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0) && (divisor_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == '0) cnt_q <= (divisor_i == '0) ? '0 : divisor_i - 1'b1;
    else cnt_q <= cnt_q - 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && divisor_i > 1 && $stable(divisor_i) |=> !tick_o); // R3
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_framer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              even_i,
  input  logic              xstop_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              txd_o
);
  line_st_e          st_q;
  logic [5:0]        cnt_q;
  logic [2:0]        bit_q;
  logic [DATA_W-1:0] sh_q;
  logic [1:0]        wlen_q;
  logic              par_en_q, par_q;
  logic [5:0]        stop_last_q;
  logic [DATA_W-1:0] masked;

  assign masked = hold_data_i & (8'hFF >> (2'd3 - wlen_i));
  assign take_o = (st_q == ST_IDLE) && load_i;
  assign busy_o = (st_q != ST_IDLE);

  always_comb begin
    case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      sh_q        <= '0;
      wlen_q      <= '0;
      par_en_q    <= 1'b0;
      par_q       <= 1'b0;
      stop_last_q <= 6'd15;
    end else begin
      case (st_q)
        ST_IDLE: if (load_i) begin
          sh_q        <= masked;
          par_q       <= even_i ? ^masked : ~^masked;
          wlen_q      <= wlen_i;
          par_en_q    <= par_en_i;
          stop_last_q <= !xstop_i ? 6'd15 : (wlen_i == 2'd0) ? 6'd23 : 6'd31;
          cnt_q       <= '0;
          st_q        <= ST_START;
        end
        ST_START: if (tick_i) begin
          if (cnt_q == 6'd15) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= ST_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          if (cnt_q == 6'd15) begin
            cnt_q <= '0;
            sh_q  <= sh_q >> 1;
            bit_q <= bit_q + 1'b1;
            if (bit_q == {1'b1, wlen_q}) st_q <= par_en_q ? ST_PAR : ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAR: if (tick_i) begin
          if (cnt_q == 6'd15) begin
            cnt_q <= '0;
            st_q  <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (cnt_q == stop_last_q) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_FRAME_STARTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> busy_o && !txd_o); // R3
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_framer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              even_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              bi_o
);
  line_st_e          st_q;
  logic [3:0]        cnt_q;
  logic [2:0]        bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              zero_q, pbad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      zero_q <= 1'b0;
      pbad_q <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      bi_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (tick_i && !rx_i) begin
          cnt_q <= '0;
          st_q  <= ST_START;
        end
        ST_START: if (tick_i) begin
          if (cnt_q == 4'd7) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            zero_q <= 1'b1;
            pbad_q <= 1'b0;
            st_q   <= rx_i ? ST_IDLE : ST_DATA;  // glitch rejected
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 4'd15) begin
            sh_q   <= {rx_i, sh_q[DATA_W-1:1]};
            zero_q <= zero_q & !rx_i;
            bit_q  <= bit_q + 1'b1;
            if (bit_q == {1'b1, wlen_i}) st_q <= par_en_i ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 4'd15) begin
            pbad_q <= (^sh_q) ^ rx_i ^ !even_i;
            zero_q <= zero_q & !rx_i;
            st_q   <= ST_STOP;
          end
        end
        ST_STOP: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 4'd15) begin
            done_o <= 1'b1;
            data_o <= sh_q >> (2'd3 - wlen_i);
            pe_o   <= par_en_i & pbad_q;
            fe_o   <= !rx_i;
            bi_o   <= zero_q & !rx_i;
            st_q   <= rx_i ? ST_IDLE : ST_HOLD;
          end
        end
        ST_HOLD: if (rx_i) st_q <= ST_IDLE;  // wait for mark after a low stop
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_RX_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((data_o & ~(8'hFF >> (2'd3 - wlen_i))) == 8'h00)); // R4
endmodule

// File: rtl/uart_framer.sv
module uart_framer
  import uart_framer_pkg::*;
#(
  parameter int unsigned DIV_RESET   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o
);
  lctl_t             lctl_q;
  logic [DIV_W-1:0]  div_q;
  logic              loop_q;
  logic [DATA_W-1:0] thr_q, rbr_q;
  logic              thr_empty_q, dr_q, oe_q, pe_q, fe_q, bi_q;
  logic [SYNC_STAGES-1:0] sync_q;

  logic tick, take, tx_busy, tx_line, rx_line;
  logic rx_done, rx_pe, rx_fe, rx_bi;
  logic [DATA_W-1:0] rx_data;
  logic rd_rbr, rd_stat, temt;
  logic [7:0] stat;

  assign rd_rbr  = rd_en_i && addr_i == A_DATA && !lctl_q.dlab;
  assign rd_stat = rd_en_i && addr_i == A_STAT;
  assign temt    = thr_empty_q && !tx_busy;
  assign stat    = {1'b0, temt, thr_empty_q, bi_q, fe_q, pe_q, oe_q, dr_q};
  assign rx_line = loop_q ? tx_line : sync_q[SYNC_STAGES-1];
  assign txd_o   = loop_q ? 1'b1 : tx_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
  end

  uart_baud_gen u_baud (
    .clk_i, .rst_ni, .divisor_i(div_q), .tick_o(tick)
  );

  uart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick),
    .wlen_i(lctl_q.wlen), .par_en_i(lctl_q.par_en), .even_i(lctl_q.even),
    .xstop_i(lctl_q.xstop), .load_i(!thr_empty_q), .hold_data_i(thr_q),
    .take_o(take), .busy_o(tx_busy), .txd_o(tx_line)
  );

  uart_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx_line),
    .wlen_i(lctl_q.wlen), .par_en_i(lctl_q.par_en), .even_i(lctl_q.even),
    .done_o(rx_done), .data_o(rx_data), .pe_o(rx_pe), .fe_o(rx_fe), .bi_o(rx_bi)
  );

  // register writes and transmit holding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lctl_q      <= '0;
      div_q       <= DIV_W'(DIV_RESET);
      loop_q      <= 1'b0;
      thr_q       <= '0;
      thr_empty_q <= 1'b1;
    end else begin
      if (take) thr_empty_q <= 1'b1;
      if (wr_en_i) begin
        case (addr_i)
          A_DATA: if (lctl_q.dlab) div_q[7:0] <= wdata_i;
                  else begin
                    thr_q       <= wdata_i;
                    thr_empty_q <= 1'b0;
                  end
          A_DIVH: if (lctl_q.dlab) div_q[15:8] <= wdata_i;
          A_LCTL: lctl_q <= wdata_i;
          A_LOOP: loop_q <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  // receive buffer and status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_q <= '0;
      dr_q  <= 1'b0;
      oe_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      if (rx_done) begin
        rbr_q <= rx_data;
        dr_q  <= 1'b1;
      end else if (rd_rbr) dr_q <= 1'b0;
      if (rx_done && dr_q && !rd_rbr) oe_q <= 1'b1;
      else if (rd_stat)               oe_q <= 1'b0;
      if (rx_done && rx_pe) pe_q <= 1'b1; else if (rd_stat) pe_q <= 1'b0;
      if (rx_done && rx_fe) fe_q <= 1'b1; else if (rd_stat) fe_q <= 1'b0;
      if (rx_done && rx_bi) bi_q <= 1'b1; else if (rd_stat) bi_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = lctl_q.dlab ? div_q[7:0] : rbr_q;
      A_DIVH:  rdata_o = lctl_q.dlab ? div_q[15:8] : 8'h00;
      A_STAT:  rdata_o = stat;
      A_LCTL:  rdata_o = lctl_q;
      A_LOOP:  rdata_o = {7'b0, loop_q};
      default: rdata_o = 8'h00;
    endcase
  end

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat[6] |-> stat[5]); // R10
  AST_DLAB_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_DATA && lctl_q.dlab && thr_empty_q |=> thr_empty_q); // R2
  AST_DR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rbr && !rx_done |=> !dr_q); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done && dr_q && !rd_rbr |=> oe_q && dr_q && rbr_q == $past(rx_data)); // R8
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat && !rx_done |=> !oe_q && !pe_q && !fe_q && !bi_q); // R9
endmodule

// File: tb/uart_framer_tb.sv
`timescale 1ns/1ps
module uart_framer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = '0, rdata;
  logic txd;
  int n_checks = 0, n_fail = 0, cyc = 0;
  bit loop_on = 1'b0, txd_low_in_loop = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (loop_on && !txd) txd_low_in_loop = 1'b1;

  uart_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd)
  );

  // {line control, transmitted byte, expected received byte}
  localparam logic [23:0] VEC [10] = '{
    24'h03_A5_A5, 24'h00_FF_1F, 24'h01_C3_03, 24'h02_80_00, 24'h1B_5A_5A,
    24'h0B_01_01, 24'h0C_15_15, 24'h1E_7F_7F, 24'h07_00_00, 24'h19_2A_2A
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_bit(input logic b);
    @(negedge clk); rxd = b; repeat (15) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] d, input int n, input bit use_par,
                          input logic pbit, input logic stopv);
    rx_bit(1'b0);
    for (int i = 0; i < n; i++) rx_bit(d[i]);
    if (use_par) rx_bit(pbit);
    rx_bit(stopv);
    rxd = 1'b1;
    idle(40);
  endtask

  // cycles from a start edge to the next rising edge and to the next start edge
  task automatic measure(input bit want_period, output int lo, output int period);
    int t0, t1, t2;
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (txd !== 1'b1) @(negedge clk);
    t1 = cyc;
    lo = t1 - t0;
    period = 0;
    if (want_period) begin
      while (txd !== 1'b0) @(negedge clk);
      t2 = cyc;
      period = t2 - t0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int lo, per;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(3'd2, v); chk("R1 status", v, 8'h60);
    rd(3'd3, v); chk("R1 line control", v, 8'h00);
    chk("R1 txd idle", txd, 1);

    // R2 divisor access
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, v); chk("R2 divisor low", v, 8'h34);
    rd(3'd1, v); chk("R2 divisor high", v, 8'h12);
    rd(3'd2, v); chk("R2 holding not loaded", v, 8'h60);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h03);
    idle(4);

    // R11 R4 R5 R6 loopback table
    wr(3'd4, 8'h01);
    loop_on = 1'b1;
    foreach (VEC[i]) begin
      wr(3'd3, VEC[i][23:16]);
      wr(3'd0, VEC[i][15:8]);
      idle(260);
      rd(3'd2, v); chk($sformatf("R11 R4 status vec%0d", i), v, 8'h61);
      rd(3'd0, v); chk($sformatf("R4 R5 R6 data vec%0d", i), v, VEC[i][7:0]);
    end

    // R8 overrun
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h11); idle(200);
    wr(3'd0, 8'h22); idle(200);
    rd(3'd2, v); chk("R8 overrun status", v, 8'h63);
    rd(3'd0, v); chk("R8 newer data kept", v, 8'h22);
    rd(3'd2, v); chk("R8 R7 overrun cleared", v, 8'h60);
    chk("R11 txd held high in loopback", txd_low_in_loop, 0);
    wr(3'd4, 8'h00);
    loop_on = 1'b0;
    idle(4);

    // R3 transmitted waveform, 8 bits even parity, data 0xA6
    wr(3'd3, 8'h1B);
    fork
      begin
        logic [10:0] exp_bits, got_bits;
        exp_bits = {1'b1, ^8'hA6, 8'hA6, 1'b0};
        while (txd !== 1'b0) @(negedge clk);
        idle(8);
        for (int b = 0; b < 11; b++) begin
          got_bits[b] = txd;
          idle(16);
        end
        chk("R3 R5 frame bits", got_bits, exp_bits);
      end
      begin
        wr(3'd0, 8'hA6);
        rd(3'd2, v); chk("R10 holding empty while shifting", v, 8'h20);
      end
    join
    idle(40);
    rd(3'd2, v); chk("R10 both empty", v, 8'h60);

    // R6 frame lengths from back-to-back characters of all ones
    begin
      logic [7:0] lc [4] = '{8'h00, 8'h04, 8'h05, 8'h0F};
      int fl [4] = '{112, 120, 144, 192};
      for (int k = 0; k < 4; k++) begin
        wr(3'd3, lc[k]);
        fork
          measure(1'b1, lo, per);
          begin
            wr(3'd0, 8'hFF);
            wr(3'd0, 8'hFF);
            rd(3'd2, v);
            if (k == 0) chk("R10 holding full", v, 8'h00);
          end
        join
        chk_rng($sformatf("R6 frame length lc=%0h", lc[k]), per, fl[k], fl[k] + 2);
        idle(220);
      end
    end

    // R3 divisor 2 doubles the bit time: start + 8 zero bits low
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h03);
    fork
      measure(1'b0, lo, per);
      wr(3'd0, 8'h00);
    join
    chk_rng("R3 divisor 2 low time", lo, 286, 290);
    idle(120);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h03);
    idle(4);

    // R5 parity on the external receive line
    wr(3'd3, 8'h1B);
    rx_frame(8'h01, 8, 1'b1, 1'b0, 1'b1);
    rd(3'd2, v); chk("R5 even parity error", v, 8'h65);
    rd(3'd0, v); chk("R5 R7 data with bad parity", v, 8'h01);
    rx_frame(8'h01, 8, 1'b1, 1'b1, 1'b1);
    rd(3'd2, v); chk("R5 even parity good", v, 8'h61);
    rd(3'd0, v);
    wr(3'd3, 8'h0B);
    rx_frame(8'h01, 8, 1'b1, 1'b0, 1'b1);
    rd(3'd2, v); chk("R5 odd parity good", v, 8'h61);
    rd(3'd0, v);
    rd(3'd2, v); chk("R7 data ready cleared", v, 8'h60);

    // R9 framing error and break
    wr(3'd3, 8'h03);
    rx_frame(8'h55, 8, 1'b0, 1'b0, 1'b0);
    rd(3'd2, v); chk("R9 framing error", v, 8'h69);
    rd(3'd0, v); chk("R9 data with framing error", v, 8'h55);
    rx_frame(8'h00, 8, 1'b0, 1'b0, 1'b0);
    rd(3'd2, v); chk("R9 break", v, 8'h79);
    rd(3'd2, v); chk("R9 status read clears errors", v, 8'h61);
    rd(3'd0, v); chk("R9 break data", v, 8'h00);

    // R12 start glitch
    @(negedge clk); rxd = 1'b0;
    idle(4);
    rxd = 1'b1;
    idle(300);
    rd(3'd2, v); chk("R12 glitch ignored", v, 8'h60);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule